// File: doc/BRIEF.md
# Cascadable Active-Low Priority Encoder

The block turns a bank of active-low request lines into the binary index of the most urgent one. It is built from identical eight-lane encoder units. Each unit has an active-low enable input, an active-low three-bit index output, a low-going "some request present" flag, and a low-going enable output. The enable output goes low only when the unit is enabled but has nothing to report. Chaining the enable output of one unit into the enable input of the next gives priority downward through the chain.

The top level links two units into a sixteen-lane encoder. The upper unit serves lanes 15..8 and the lower unit serves lanes 7..0. Lane 15 is the most urgent. The upper unit's request flag becomes the most significant index bit. The low index bits are the bitwise AND of the two units' active-low codes, because an idle unit drives its code to all ones. The combined request flag is the AND of the two unit flags. The block is purely combinational and holds no state.

Top module: `prio_chain`

## Requirements
- R1: Within one unit, request lane 7 has the highest priority and lane 0 the lowest. When the unit is enabled, its 3-bit code output is the bitwise inverse of the highest asserted lane's index. For example, lane 5 alone gives code 3'b010.
- R2: A unit's group flag is low exactly when its enable input is low and at least one of its request lines is low.
- R3: A unit's enable output is low exactly when its enable input is low and none of its request lines is low.
- R4: While a unit's enable input is high, its code, group flag and enable output are all high, whatever the requests.
- R5: In the 16-lane chain with `en_in_n` low, `code_n` is the bitwise inverse of the 4-bit index of the highest asserted lane, with lane 15 the highest. Bit 3 of `code_n` is low exactly when some lane in 15..8 is asserted.
- R6: In the enabled chain with no lane asserted, `code_n` reads 4'b1111, `grp_n` is high and `en_out_n` is low.
- R7: With `en_in_n` high, the chain drives `code_n` to 4'b1111 and drives `grp_n` and `en_out_n` high for every request pattern.
- R8: In the enabled chain, while any lane in 15..8 is asserted, the pattern on lanes 7..0 has no effect on `code_n`, `grp_n` or `en_out_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_n | input | 16 | Active-low request lines; bit 15 has the highest priority |
| en_in_n | input | 1 | Active-low enable for the whole chain |
| code_n | output | 4 | Active-low index of the highest asserted request |
| grp_n | output | 1 | Low when enabled and at least one request is asserted |
| en_out_n | output | 1 | Low when enabled and no request is asserted; feeds a further chain stage |

## Verification
All 65,536 request patterns are applied to the chain, once with the enable low and once with it high. This separates the correct choice of the highest lane from errors in the lane order, in the merge of the two partial codes, and in the enable gating. Patterns with an upper lane asserted and arbitrary lower lanes show whether the lower unit is held off. The all-idle pattern shows the 1111 code and the enable-out handshake. A standalone unit is also swept over all 256 patterns in both enable states, to confirm the single-unit flag and enable-out behaviour.

// File: rtl/prio_enc_pkg.sv
// Package: shared sizing for the cascadable priority encoder.
// Assumes lane counts are powers of two and at least two.
package prio_enc_pkg;
    localparam int LANES_PER_UNIT = 8;
    localparam int UNIT_COUNT     = 2;
endpackage

// File: rtl/prio_scan.sv
// prio_scan: finds the highest-index low bit of an active-low vector.
// Output idx is valid only when hit is high. Purely combinational.
module prio_scan #(
    parameter int W = 8,
    localparam int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req_n,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // Ascending scan; a later (higher) lane overrides an earlier one.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (!req_n[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // Check that a reported hit points at a lane that is really asserted.
    always_comb begin
        // R1
        scan_hit_valid_chk: assert (!hit || !req_n[idx]);
    end
endmodule

// File: rtl/prio_unit.sv
// prio_unit: one W-lane active-low priority encoder with chain handshake.
// Assumes W is a power of two. Disabled units drive every output high.
module prio_unit #(
    parameter int W = 8,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  req_n,
    input  logic          ei_n,
    output logic [CW-1:0] code_n,
    output logic          gs_n,
    output logic          eo_n
);
    logic          hit;
    logic [CW-1:0] idx;
    logic          higher_clear;

    prio_scan #(.W(W)) u_scan (
        .req_n (req_n),
        .hit   (hit),
        .idx   (idx)
    );

    // Gate the scan result by the enable and form the handshake outputs.
    always_comb begin
        code_n = (!ei_n && hit) ? ~idx : '1;
        gs_n   = !(!ei_n && hit);
        eo_n   = !(!ei_n && !hit);
    end

    // Checker helper: no lane above the reported one is asserted.
    always_comb begin
        higher_clear = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (i > int'(CW'(~code_n)) && !req_n[i]) higher_clear = 1'b0;
        end
    end

    // Guard the unit's output relations.
    always_comb begin
        // R1
        unit_highest_chk: assert (gs_n || (higher_clear && !req_n[CW'(~code_n)]));
        // R2
        unit_flag_exclusive_chk: assert (gs_n || eo_n);
        // R3
        unit_eo_needs_en_chk: assert (eo_n || !ei_n);
        // R4
        unit_disabled_high_chk: assert (!ei_n || (gs_n && eo_n && code_n == '1));
    end
endmodule

// File: rtl/code_merge.sv
// code_merge: combines per-unit codes and flags into the chain outputs.
// Assumes idle units drive all-ones codes, so the low bits are a plain AND.
// The high bits are the inverted index of the highest unit with a request.
module code_merge #(
    parameter int N  = 2,
    parameter int CW = 3,
    localparam int UW = $clog2(N)
) (
    input  logic [N*CW-1:0]  unit_code_n,
    input  logic [N-1:0]     unit_gs_n,
    output logic [UW+CW-1:0] code_n,
    output logic             grp_n
);
    logic          any_unit;
    logic [UW-1:0] unit_idx;
    logic [CW-1:0] low_n;

    prio_scan #(.W(N)) u_unit_scan (
        .req_n (unit_gs_n),
        .hit   (any_unit),
        .idx   (unit_idx)
    );

    // AND the partial codes of all units.
    always_comb begin
        low_n = '1;
        for (int u = 0; u < N; u++) low_n &= unit_code_n[u*CW +: CW];
    end

    // Assemble the full code and the merged group flag.
    always_comb begin
        code_n = {(any_unit ? ~unit_idx : {UW{1'b1}}), low_n};
        grp_n  = &unit_gs_n;
    end

    // Check that at most one unit reports a request at a time.
    always_comb begin
        // R5
        one_unit_active_chk: assert ($countones(~unit_gs_n) <= 1);
    end
endmodule

// File: rtl/prio_chain.sv
// prio_chain: top-level chain of prio_unit stages forming a wide encoder.
// The top unit serves the highest lanes. Each unit's enable output feeds
// the enable input of the unit below. Assumes UNITS >= 2, a power of two.
module prio_chain
    import prio_enc_pkg::*;
#(
    parameter int LANES = LANES_PER_UNIT,
    parameter int UNITS = UNIT_COUNT,
    localparam int CW   = $clog2(LANES),
    localparam int UW   = $clog2(UNITS),
    localparam int TW   = LANES * UNITS
) (
    input  logic [TW-1:0]    req_n,
    input  logic             en_in_n,
    output logic [UW+CW-1:0] code_n,
    output logic             grp_n,
    output logic             en_out_n
);
    logic [UNITS-1:0]    ei_n;
    logic [UNITS-1:0]    eo_n;
    logic [UNITS-1:0]    gs_n;
    logic [UNITS*CW-1:0] ucode_n;
    logic                upper_hit;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        // Chain the enable from the highest unit downward.
        if (u == UNITS - 1) begin : g_head
            assign ei_n[u] = en_in_n;
        end else begin : g_link
            assign ei_n[u] = eo_n[u+1];
        end

        prio_unit #(.W(LANES)) u_unit (
            .req_n  (req_n[u*LANES +: LANES]),
            .ei_n   (ei_n[u]),
            .code_n (ucode_n[u*CW +: CW]),
            .gs_n   (gs_n[u]),
            .eo_n   (eo_n[u])
        );
    end

    code_merge #(.N(UNITS), .CW(CW)) u_merge (
        .unit_code_n (ucode_n),
        .unit_gs_n   (gs_n),
        .code_n      (code_n),
        .grp_n       (grp_n)
    );

    // The enable output of the lowest unit is the chain's enable output.
    assign en_out_n = eo_n[0];

    // Checker helper: any request in the top unit's lanes.
    always_comb upper_hit = (req_n[TW-1 -: LANES] != '1);

    // Guard the chain-level relations.
    always_comb begin
        // R5
        chain_index_asserted_chk: assert (grp_n || !req_n[code_n ^ '1]);
        // R6
        chain_idle_chk: assert (en_in_n || req_n != '1 || (code_n == '1 && grp_n && !en_out_n));
        // R7
        chain_disabled_chk: assert (!en_in_n || (code_n == '1 && grp_n && en_out_n));
        // R8
        chain_upper_wins_chk: assert (en_in_n || !upper_hit || code_n[UW+CW-1 -: UW] == '0);
    end
endmodule

// File: tb/prio_chain_test.sv
// prio_chain_test: exhaustive sweep of the 16-lane chain and of one unit.
module prio_chain_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] req_n = '1;
    logic        en_in_n = 1'b1;
    logic [3:0]  code_n;
    logic        grp_n, en_out_n;

    logic [7:0]  ureq_n = '1;
    logic        uei_n = 1'b1;
    logic [2:0]  ucode_n;
    logic        ugs_n, ueo_n;

    prio_chain uut (
        .req_n (req_n), .en_in_n (en_in_n),
        .code_n (code_n), .grp_n (grp_n), .en_out_n (en_out_n)
    );

    prio_unit #(.W(8)) uut_unit (
        .req_n (ureq_n), .ei_n (uei_n),
        .code_n (ucode_n), .gs_n (ugs_n), .eo_n (ueo_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            if (failures < 20)
                $display("FAIL %s req=%h en=%b act=%h exp=%h", req, req_n, en_in_n, act, exp);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int best;
        logic [3:0] exp_code;
        logic [3:0] ref_code;
        logic ref_grp, ref_eo;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: disabled, idle, all outputs high (R7).
        check(code_n == 4'hF && grp_n && en_out_n, "R7 reset", {code_n, grp_n, en_out_n}, 6'h3F);

        // Standalone unit, both enable states (R1..R4).
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 256; p++) begin
                @(negedge clk);
                uei_n = e[0];
                ureq_n = p[7:0];
                #1;
                best = -1;
                for (int i = 7; i >= 0; i--) if (!ureq_n[i] && best < 0) best = i;
                if (e == 1) begin
                    check(ucode_n == 3'h7 && ugs_n && ueo_n, "R4 unit disabled", {ucode_n, ugs_n, ueo_n}, 5'h1F);
                end else begin
                    exp_code = (best < 0) ? 4'hF : ~4'(best);
                    check(ucode_n == exp_code[2:0], "R1 unit code", ucode_n, exp_code[2:0]);
                    check(ugs_n == (best < 0), "R2 unit group flag", ugs_n, best < 0);
                    check(ueo_n == (best >= 0), "R3 unit enable out", ueo_n, best >= 0);
                end
            end
        end

        // Full chain sweep, enabled then disabled (R5..R8).
        for (int e = 0; e < 2; e++) begin
            for (int p = 0; p < 65536; p++) begin
                @(negedge clk);
                en_in_n = e[0];
                req_n = p[15:0];
                #1;
                best = -1;
                for (int i = 15; i >= 0; i--) if (!req_n[i] && best < 0) best = i;
                if (e == 1) begin
                    check(code_n == 4'hF && grp_n && en_out_n, "R7 chain disabled", {code_n, grp_n, en_out_n}, 6'h3F);
                end else if (best < 0) begin
                    check(code_n == 4'hF && grp_n && !en_out_n, "R6 chain idle", {code_n, grp_n, en_out_n}, 6'h3E);
                end else begin
                    exp_code = ~4'(best);
                    check(code_n == exp_code, "R5 chain code", code_n, exp_code);
                    check(!grp_n && en_out_n, "R5 chain flags", {grp_n, en_out_n}, 2'b01);
                end
            end
        end

        // Upper lanes asserted: the lower byte must not matter (R8).
        for (int up = 0; up < 255; up++) begin
            @(negedge clk);
            en_in_n = 1'b0;
            req_n = {up[7:0], 8'hFF};
            #1;
            ref_code = code_n;
            ref_grp = grp_n;
            ref_eo = en_out_n;
            for (int lo = 0; lo < 255; lo += 37) begin
                @(negedge clk);
                req_n = {up[7:0], lo[7:0]};
                #1;
                check(code_n == ref_code && grp_n == ref_grp && en_out_n == ref_eo,
                      "R8 lower lanes ignored", {code_n, grp_n, en_out_n}, {ref_code, ref_grp, ref_eo});
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule